// File: doc/BRIEF.md
# MRU-Tour Set Replacement Controller

This block holds the replacement state of one set in a set-associative last-level cache and names a victim way on demand. Every way has a valid bit, a bit that marks the line most recently used, and a tenure bit. The tenure bit tells apart lines that have only been most recently used once, when they were filled, from lines that came back to the most-recently-used slot after leaving it. Lines with a single tenure are the first choice for eviction, because most such lines are never touched again.

The cache controller reports each access with a strobe, a fill-or-hit flag and a way index. The victim index and a two-bit code that says which rule picked it are always present on combinational outputs. A short recency list keeps the last few distinct ways referenced. Those ways are never chosen. A depth of one gives the basic policy, and the default depth of three is the preferred setting. Random choice comes from a free-running LFSR. The LFSR gives the starting point of a rotating scan, so the scan always returns an eligible way in the same cycle.

Top module: `mrut_set_policy`

## Requirements
- R1: A synchronous active-high reset clears all valid, MRU and tenure state and empties the recency list. After reset the victim is way 0 with kind code 0.
- R2: A fill of way w marks w valid with its tenure bit clear, makes w the only MRU line and puts w at the front of the recency list.
- R3: A hit to a valid way that is not the MRU line makes it MRU, sets its tenure bit and moves it to the front of the recency list.
- R4: A hit to the way that is already MRU changes no valid, tenure, MRU or recency state.
- R5: A hit to a way that is not valid is ignored and leaves all state unchanged.
- R6: While any way is invalid, the victim is the lowest-indexed invalid way and victim_kind is 0.
- R7: When every way is valid and at least one unprotected way has its tenure bit clear, the victim is one of those ways and victim_kind is 1.
- R8: When every way is valid and no unprotected way has its tenure bit clear, the victim is any unprotected way and victim_kind is 2.
- R9: The protected ways are the last RECENT_DEPTH distinct ways that were filled or re-hit, with the MRU line at the front. A protected way is never the victim while the set is full.
- R10: Random choice uses a free-running 16-bit maximal-length LFSR, which never holds zero. When a pool has more than one member, the victim changes across cycles among the members of that pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_fill | input | 1 | 1 means the access is a fill, 0 means a hit |
| acc_way | input | WAY_W | Way index of the access |
| victim_way | output | WAY_W | Chosen victim way |
| victim_kind | output | 2 | Rule that chose the victim: 0 invalid way, 1 single-tenure pool, 2 fallback pool |

## Verification
Internal state shows at the ports through the victim. A wrong tenure bit moves victim_kind between 1 and 2, or lets a re-used line appear as a single-tenure victim. A wrong recency entry exposes a protected way, and a wrong valid bit shifts the lowest-invalid choice. Each of these errors shows in the combinational outputs one cycle after the access that caused it. The bench therefore compares the victim against a reference model after every access. It also arranges states in which the eligible pool has exactly one member, so that the expected victim is exact.

// File: rtl/mrut_pkg.sv
package mrut_pkg;

    typedef enum logic [1:0] {
        VK_INVALID = 2'd0,
        VK_SINGLE  = 2'd1,
        VK_ANY     = 2'd2
    } victim_kind_e;

    localparam int          RNG_W    = 16;
    // x^16 + x^14 + x^13 + x^11 + 1, right-shifting Galois form
    localparam logic [15:0] RNG_TAPS = 16'hB400;
    localparam logic [15:0] RNG_SEED = 16'hACE1;

    function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
        logic [RNG_W-1:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ RNG_TAPS;
        return n;
    endfunction

endpackage

// File: rtl/mrut_lfsr.sv
module mrut_lfsr
    import mrut_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic [RNG_W-1:0] state
);
    logic [RNG_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= RNG_SEED;
        else     state_q <= rng_step(state_q);
    end

    assign state = state_q;

    AST_RNG_NONZERO: assert property (@(posedge clk) disable iff (rst) state_q != '0); // R10
endmodule

// File: rtl/mrut_recency.sv
module mrut_recency #(
    parameter int WAYS  = 16,
    parameter int DEPTH = 3,
    parameter int WAY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [WAY_W-1:0] upd_way,
    output logic [WAYS-1:0]  protect_mask,
    output logic [WAY_W-1:0] head_way,
    output logic             head_valid
);
    logic [WAY_W-1:0] ent_way_q [DEPTH];
    logic             ent_vld_q [DEPTH];
    logic [WAY_W-1:0] ent_way_d [DEPTH];
    logic             ent_vld_d [DEPTH];

    // Move-to-front: slots at or above the old position of upd_way shift down.
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            ent_way_d[i] = ent_way_q[i];
            ent_vld_d[i] = ent_vld_q[i];
            if (upd) begin
                if (i == 0) begin
                    ent_way_d[i] = upd_way;
                    ent_vld_d[i] = 1'b1;
                end else if (!seen) begin
                    ent_way_d[i] = ent_way_q[i-1];
                    ent_vld_d[i] = ent_vld_q[i-1];
                end
            end
            seen = seen | (ent_vld_q[i] && (ent_way_q[i] == upd_way));
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst) begin
                ent_way_q[i] <= '0;
                ent_vld_q[i] <= 1'b0;
            end else begin
                ent_way_q[i] <= ent_way_d[i];
                ent_vld_q[i] <= ent_vld_d[i];
            end
        end
    end

    always_comb begin
        protect_mask = '0;
        for (int i = 0; i < DEPTH; i++)
            if (ent_vld_q[i]) protect_mask[ent_way_q[i]] = 1'b1;
    end

    assign head_way   = ent_way_q[0];
    assign head_valid = ent_vld_q[0];

    for (genvar i = 0; i < DEPTH; i++) begin : g_chk_i
        for (genvar j = i + 1; j < DEPTH; j++) begin : g_chk_j
            AST_REC_DISTINCT: assert property (@(posedge clk) disable iff (rst)
                (ent_vld_q[i] && ent_vld_q[j]) |-> (ent_way_q[i] != ent_way_q[j])); // R9
        end
        if (i > 0) begin : g_fill_order
            AST_REC_PACKED: assert property (@(posedge clk) disable iff (rst)
                ent_vld_q[i] |-> ent_vld_q[i-1]); // R9
        end
    end
endmodule

// File: rtl/mrut_victim_pick.sv
module mrut_victim_pick #(
    parameter int WAYS  = 16,
    parameter int WAY_W = 4
) (
    input  logic [WAYS-1:0]  eligible,
    input  logic [WAY_W-1:0] start,
    output logic [WAY_W-1:0] pick,
    output logic             found
);
    // Rotating scan from start; the nearest eligible way wins.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int k = WAYS - 1; k >= 0; k--) begin
            int idx;
            idx = (int'(start) + k) % WAYS;
            if (eligible[idx]) begin
                pick  = WAY_W'(idx);
                found = 1'b1;
            end
        end
    end

    always_comb begin
        if (found) assert (eligible[pick]); // R7
    end
endmodule

// File: rtl/mrut_set_policy.sv
module mrut_set_policy
    import mrut_pkg::*;
#(
    parameter  int NUM_WAYS     = 16,
    parameter  int RECENT_DEPTH = 3,
    localparam int WAY_W        = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_fill,
    input  logic [WAY_W-1:0] acc_way,
    output logic [WAY_W-1:0] victim_way,
    output logic [1:0]       victim_kind
);
    logic [NUM_WAYS-1:0] valid_q, mru_q, tenure_q;
    logic [NUM_WAYS-1:0] acc_onehot, protect;
    logic [WAY_W-1:0]    head_way, low_inv, scan_start, single_pick, any_pick;
    logic                head_valid, single_found, any_found;
    logic                tgt_valid, tgt_mru, do_fill, do_hit, touch;
    logic [RNG_W-1:0]    rng;
    victim_kind_e        kind;

    for (genvar i = 0; i < NUM_WAYS; i++) begin : g_dec
        assign acc_onehot[i] = (acc_way == WAY_W'(i));
    end

    assign tgt_valid = |(acc_onehot & valid_q);
    assign tgt_mru   = |(acc_onehot & mru_q);
    assign do_fill   = acc_valid && acc_fill && (|acc_onehot);
    assign do_hit    = acc_valid && !acc_fill && tgt_valid && !tgt_mru;
    assign touch     = do_fill || do_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= '0;
            mru_q    <= '0;
            tenure_q <= '0;
        end else if (touch) begin
            mru_q <= acc_onehot;
            if (do_fill) begin
                valid_q  <= valid_q | acc_onehot;
                tenure_q <= tenure_q & ~acc_onehot;
            end else begin
                tenure_q <= tenure_q | acc_onehot;
            end
        end
    end

    mrut_recency #(.WAYS(NUM_WAYS), .DEPTH(RECENT_DEPTH), .WAY_W(WAY_W)) u_recency (
        .clk          (clk),
        .rst          (rst),
        .upd          (touch),
        .upd_way      (acc_way),
        .protect_mask (protect),
        .head_way     (head_way),
        .head_valid   (head_valid)
    );

    mrut_lfsr u_rng (
        .clk   (clk),
        .rst   (rst),
        .state (rng)
    );

    assign scan_start = WAY_W'(rng % NUM_WAYS);

    mrut_victim_pick #(.WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_pick_single (
        .eligible (valid_q & ~tenure_q & ~protect),
        .start    (scan_start),
        .pick     (single_pick),
        .found    (single_found)
    );

    mrut_victim_pick #(.WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_pick_any (
        .eligible (valid_q & ~protect),
        .start    (scan_start),
        .pick     (any_pick),
        .found    (any_found)
    );

    always_comb begin
        low_inv = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--)
            if (!valid_q[i]) low_inv = WAY_W'(i);
    end

    always_comb begin
        if (!(&valid_q)) begin
            victim_way = low_inv;
            kind       = VK_INVALID;
        end else if (single_found) begin
            victim_way = single_pick;
            kind       = VK_SINGLE;
        end else if (any_found) begin
            victim_way = any_pick;
            kind       = VK_ANY;
        end else begin
            victim_way = '0;
            kind       = VK_ANY;
        end
    end

    assign victim_kind = kind;

    AST_MRU_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(mru_q)); // R2
    AST_MRU_VALID: assert property (@(posedge clk) disable iff (rst) (mru_q & ~valid_q) == '0); // R2
    AST_MRU_HEAD: assert property (@(posedge clk) disable iff (rst)
        head_valid |-> (mru_q[head_way] && $onehot(mru_q))); // R9
    AST_FILL_FIRST_TENURE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_fill) |=> (!tenure_q[$past(acc_way)] && mru_q[$past(acc_way)] && valid_q[$past(acc_way)])); // R2
    AST_REHIT_SETS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_fill && valid_q[acc_way] && !mru_q[acc_way]) |=> (tenure_q[$past(acc_way)] && mru_q[$past(acc_way)])); // R3
    AST_MRU_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_fill && mru_q[acc_way]) |=> ($stable(tenure_q) && $stable(mru_q) && $stable(valid_q))); // R4
    AST_INVALID_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_fill && !valid_q[acc_way]) |=> ($stable(tenure_q) && $stable(mru_q) && $stable(valid_q))); // R5
    AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (rst)
        (~valid_q != '0) |-> (!valid_q[victim_way] && victim_kind == 2'd0)); // R6
    AST_SINGLE_POOL: assert property (@(posedge clk) disable iff (rst)
        (victim_kind == 2'd1) |-> (!tenure_q[victim_way] && (&valid_q))); // R7
    AST_FALLBACK_ONLY: assert property (@(posedge clk) disable iff (rst)
        (victim_kind == 2'd2) |-> ((valid_q & ~tenure_q & ~protect) == '0)); // R8
    AST_NOT_PROTECTED: assert property (@(posedge clk) disable iff (rst)
        (victim_kind != 2'd0) |-> !protect[victim_way]); // R9
endmodule

// File: tb/mrut_set_policy_bench.sv
module mrut_set_policy_bench;
    localparam int W = 16;
    localparam int D = 3;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0;
    logic          acc_fill = 1'b0;
    logic [WW-1:0] acc_way = '0;
    logic [WW-1:0] victim_way;
    logic [1:0]    victim_kind;

    mrut_set_policy #(.NUM_WAYS(W), .RECENT_DEPTH(D)) u_mrut_set_policy (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_fill(acc_fill),
        .acc_way(acc_way), .victim_way(victim_way), .victim_kind(victim_kind)
    );

    always #5 clk = ~clk;

    int total = 0;
    int failed = 0;
    bit done = 0;

    bit m_valid [W];
    bit m_ten [W];
    int m_mru;
    int rec [D];
    int rec_n;
    bit [W-1:0] seen_victims;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < W; i++) begin m_valid[i] = 0; m_ten[i] = 0; end
        m_mru = -1;
        rec_n = 0;
    endfunction

    function automatic void model_touch(input int w);
        int p;
        p = -1;
        for (int i = 0; i < rec_n; i++) if (rec[i] == w) p = i;
        if (p < 0) begin
            p = (rec_n < D) ? rec_n : D - 1;
            if (rec_n < D) rec_n++;
        end
        for (int i = p; i > 0; i--) rec[i] = rec[i-1];
        rec[0] = w;
        m_mru = w;
    endfunction

    function automatic void model_access(input bit f, input int w);
        if (f) begin
            m_valid[w] = 1; m_ten[w] = 0; model_touch(w);
        end else if (m_valid[w] && w != m_mru) begin
            m_ten[w] = 1; model_touch(w);
        end
    endfunction

    function automatic bit [W-1:0] prot_mask();
        bit [W-1:0] m;
        m = '0;
        for (int i = 0; i < rec_n; i++) m[rec[i]] = 1;
        return m;
    endfunction

    task automatic check_victim();
        int inv;
        bit [W-1:0] pm, single, anyp;
        int v;
        inv = -1;
        for (int i = W - 1; i >= 0; i--) if (!m_valid[i]) inv = i;
        pm = prot_mask();
        single = '0; anyp = '0;
        for (int i = 0; i < W; i++) begin
            if (!pm[i]) anyp[i] = 1;
            if (!pm[i] && !m_ten[i]) single[i] = 1;
        end
        v = int'(victim_way);
        if (inv >= 0) begin
            chk(victim_kind == 2'd0, "R6 kind", int'(victim_kind), 0);
            chk(v == inv, "R6 lowest invalid way", v, inv);
        end else if (single != '0) begin
            chk(victim_kind == 2'd1, "R7 kind", int'(victim_kind), 1);
            chk(single[v], "R7 victim in single-tenure pool", v, -1);
            chk(!pm[v], "R9 victim not protected", v, -1);
            if ($countones(single) > 1) seen_victims[v] = 1;
        end else begin
            chk(victim_kind == 2'd2, "R8 kind", int'(victim_kind), 2);
            chk(anyp[v], "R8 victim in fallback pool", v, -1);
            chk(!pm[v], "R9 victim not protected", v, -1);
        end
    endtask

    task automatic access(input bit f, input int w);
        acc_valid = 1; acc_fill = f; acc_way = WW'(w);
        @(negedge clk);
        acc_valid = 0;
        model_access(f, w);
        check_victim();
    endtask

    task automatic do_reset();
        rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        model_reset();
        chk(victim_way == '0, "R1 reset victim way", int'(victim_way), 0);
        chk(victim_kind == 2'd0, "R1 reset victim kind", int'(victim_kind), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240917));
        seen_victims = '0;
        @(negedge clk);
        do_reset();

        // R2/R5: fill 3, ignored hit to invalid 5
        access(1, 3);
        chk(victim_way == 4'd0, "R2 fill keeps way 0 lowest invalid", int'(victim_way), 0);
        access(0, 5);
        access(1, 0); access(1, 1); access(1, 2); access(1, 4);
        chk(victim_way == 4'd5, "R5 hit to invalid way left it invalid", int'(victim_way), 5);
        for (int i = 5; i < W; i++) access(1, i);

        // R3: re-hits set tenure; only way 15 stays single-tenure and unprotected
        for (int i = 0; i < 15; i++) access(0, i);
        chk(victim_way == 4'd15 && victim_kind == 2'd1, "R7 sole candidate way", int'(victim_way), 15);
        access(0, 15);
        chk(victim_kind == 2'd2, "R3 re-hit moved last line out of single pool", int'(victim_kind), 2);
        access(0, 15);
        access(0, 13);

        // R4: fill way 0, hit it as MRU, then push it out of the recency list
        access(1, 0);
        access(0, 0);
        access(0, 1); access(0, 2); access(0, 3);
        chk(victim_way == 4'd0 && victim_kind == 2'd1, "R4 MRU hit kept tenure clear", int'(victim_kind), 1);

        // R1: reset in the middle of a run
        do_reset();
        for (int i = 0; i < W; i++) access(1, i);

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 30) access(1, int'(victim_way));
            else if (r < 40) access(1, int'($urandom_range(0, W - 1)));
            else access(0, int'($urandom_range(0, W - 1)));
            if (n % 50 == 0) begin
                @(negedge clk);
                check_victim();
            end
        end

        chk($countones(seen_victims) >= 2, "R10 random choice varies", $countones(seen_victims), 2);

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule